// File: doc/BRIEF.md
# Sign-aligned multi-scalar digit recoder

The block turns four unsigned scalars of `W` bits each into `W+1` signed digit-columns, which drive a four-way multi-scalar point multiplication. The first scalar is the lead. It must be odd. Its recoded digits are never zero: every one of them is either +1 or -1, and the top one is +1. Each of the other three scalars is recoded so that its digit at a given position is either zero or carries the same sign as the lead's digit there. Each column is therefore one sign plus three "present" bits. The three bits pick one of eight precomputed points, and the sign picks that point or its negation.

A one-cycle `start` pulse captures the four scalars. A fixed sequence then runs: `W` iterations of six steps each, then one step for the top column. The number of cycles does not depend on the scalar values. The block writes each column into an internal buffer at the column's position. It raises `done` for one cycle after the last column is written. The consumer then reads the columns by index through `rd_idx` and `rd_col`. The buffer keeps its contents until the next run.

Top module: `sign_aligned_recoder`

## Requirements
- R1: For each scalar k, the sum over the columns j of s_j * c_kj * 2^j equals the scalar's input value. Here s_j is +1 when bit 3 of column j is 1 and -1 when it is 0. For the lead, c_0j is always 1. For auxiliary scalars 1, 2 and 3, c_kj is bit 0, 1 and 2 of the column respectively. As a result, an auxiliary digit is either zero or equal to the lead's digit.
- R2: For every column j below `W`, the sign bit (bit 3) equals bit j+1 of the lead scalar. A bit position at `W` or above counts as 0.
- R3: Exactly `W+1` columns exist, at indices 0 to `W`. Reading any index above `W` returns 0.
- R4: Column `W` always has its sign bit at 1, so the lead's top digit is +1.
- R5: `done` is high in the cycle after rising edge number 6*`W`+2, where the edge that samples `start` counts as number 1. This latency is the same for every input value.
- R6: `done` is high for exactly one cycle per run.
- R7: A `start` pulse while a run is in progress is ignored. The run finishes at its normal time, with columns computed from the scalars captured at its own start.
- R8: After `done`, the columns stay unchanged until the next accepted `start`, even when the scalar inputs change.
- R9: After reset, `done` is low and every column reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle; ignored while a run is in progress |
| lead_scalar | input | W | Lead scalar; must be odd |
| aux1_scalar | input | W | First auxiliary scalar (column bit 0) |
| aux2_scalar | input | W | Second auxiliary scalar (column bit 1) |
| aux3_scalar | input | W | Third auxiliary scalar (column bit 2) |
| done | output | 1 | One-cycle pulse after column W is written |
| rd_idx | input | $clog2(W+1) | Column index to read |
| rd_col | output | 4 | Column at rd_idx: {sign, aux3, aux2, aux1} |

## Verification
The assertions check four things on every cycle:
- the fixed latency from start to `done`, measured by a cycle counter;
- that `done` lasts one cycle;
- that the top column is written positive;
- that the iteration index only moves forward during a run.

At the top step they also check that each running auxiliary scalar has shrunk to 0 or 1, which is the property that makes the last column exact.

Only the bench's scenarios can show the following:
- that the columns rebuild every input value;
- that the signs follow the lead's bits;
- that a start pulse in the middle of a run is ignored;
- that results stay put after the run.

The bench checks each of these in a full sweep of a 3-bit configuration and on directed and pseudo-random 64-bit vectors.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Control states; one iteration walks SGN through ADJ
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SGN,
    ST_CAP1,
    ST_CAP2,
    ST_CAP3,
    ST_SHF,
    ST_ADJ,
    ST_TOP
  } sar_state_e;

  // Column code layout: bit 3 sign (1 = positive), bits 2..0 auxiliary presence
  function automatic logic [3:0] pack_col(input logic pos, input logic [2:0] present);
    return {pos, present};
  endfunction

  function automatic sar_state_e next_state(input sar_state_e cur, input logic go,
                                            input logic last_iter);
    sar_state_e nx;
    case (cur)
      ST_IDLE: nx = go ? ST_SGN : ST_IDLE;
      ST_SGN:  nx = ST_CAP1;
      ST_CAP1: nx = ST_CAP2;
      ST_CAP2: nx = ST_CAP3;
      ST_CAP3: nx = ST_SHF;
      ST_SHF:  nx = ST_ADJ;
      ST_ADJ:  nx = last_iter ? ST_TOP : ST_SGN;
      default: nx = ST_IDLE;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter  int W    = 64,
  localparam int IDXW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            ph_load,
  output logic            ph_sgn,
  output logic [2:0]      ph_cap,
  output logic            ph_shf,
  output logic            ph_adj,
  output logic            ph_top,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] iter
);
  localparam logic [IDXW-1:0] LAST = IDXW'(W - 1);

  sar_state_e st_q, st_d;
  logic       last_iter;

  assign last_iter = (iter == LAST);

  always_comb st_d = next_state(st_q, start, last_iter);

  assign busy      = (st_q != ST_IDLE);
  assign ph_load   = (st_q == ST_IDLE) && start;
  assign ph_sgn    = (st_q == ST_SGN);
  assign ph_cap[0] = (st_q == ST_CAP1);
  assign ph_cap[1] = (st_q == ST_CAP2);
  assign ph_cap[2] = (st_q == ST_CAP3);
  assign ph_shf    = (st_q == ST_SHF);
  assign ph_adj    = (st_q == ST_ADJ);
  assign ph_top    = (st_q == ST_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      iter <= '0;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= ph_top;
      if (ph_load)
        iter <= '0;
      else if (ph_adj && !last_iter)
        iter <= iter + 1'b1;
    end
  end
endmodule

// File: rtl/sar_lane.sv
// One auxiliary running scalar: capture low bit, halve, then correct by +1
// when the digit was taken with a negative column sign.
module sar_lane #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         cap,
  input  logic         shf,
  input  logic         adj,
  input  logic         neg,
  output logic [W-1:0] acc_q,
  output logic         bit_q
);
  function automatic logic [W-1:0] halve(input logic [W-1:0] v);
    return {1'b0, v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] bump(input logic [W-1:0] v, input logic inc);
    return v + W'(inc);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else if (load) begin
      acc_q <= ld_val;
      bit_q <= 1'b0;
    end else if (cap) begin
      bit_q <= acc_q[0];
    end else if (shf) begin
      acc_q <= halve(acc_q);
    end else if (adj) begin
      acc_q <= bump(acc_q, neg & bit_q);
    end
  end
endmodule

// File: rtl/sar_colbuf.sv
// Column store; entries above W are never written and read as zero.
module sar_colbuf #(
  parameter  int W     = 64,
  localparam int IDXW  = $clog2(W + 1),
  localparam int DEPTH = 1 << IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [3:0]      wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [3:0]      rdata
);
  logic [3:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/sign_aligned_recoder.sv
module sign_aligned_recoder
  import sar_pkg::*;
#(
  parameter  int W    = 64,
  localparam int IDXW = $clog2(W + 1),
  localparam int NAUX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    lead_scalar,
  input  logic [W-1:0]    aux1_scalar,
  input  logic [W-1:0]    aux2_scalar,
  input  logic [W-1:0]    aux3_scalar,
  output logic            done,
  input  logic [IDXW-1:0] rd_idx,
  output logic [3:0]      rd_col
);
  // Named internal events, observed by the bound checker
  logic                      ph_load, ph_sgn, ph_shf, ph_adj, ph_top, busy;
  logic [2:0]                ph_cap;
  logic [IDXW-1:0]           iter;
  logic [W-1:0]              lead_q;
  logic                      sgn_q;
  logic [NAUX-1:0][W-1:0]    lane_acc;
  logic [NAUX-1:0]           lane_bit;
  logic [NAUX-1:0][W-1:0]    lane_in;
  logic                      wr_en;
  logic [IDXW-1:0]           wr_idx;
  logic [3:0]                wr_data;

  sar_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ph_load(ph_load), .ph_sgn(ph_sgn), .ph_cap(ph_cap), .ph_shf(ph_shf),
    .ph_adj(ph_adj), .ph_top(ph_top), .busy(busy), .done(done), .iter(iter)
  );

  // Lead scalar: sign of column j is bit j+1, read then shifted out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= '0;
      sgn_q  <= 1'b0;
    end else if (ph_load) begin
      lead_q <= lead_scalar;
      sgn_q  <= 1'b0;
    end else if (ph_sgn) begin
      sgn_q  <= lead_q[1];
      lead_q <= {1'b0, lead_q[W-1:1]};
    end
  end

  assign lane_in[0] = aux1_scalar;
  assign lane_in[1] = aux2_scalar;
  assign lane_in[2] = aux3_scalar;

  for (genvar k = 0; k < NAUX; k++) begin : g_lane
    sar_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .ld_val(lane_in[k]),
      .cap(ph_cap[k]), .shf(ph_shf), .adj(ph_adj), .neg(~sgn_q),
      .acc_q(lane_acc[k]), .bit_q(lane_bit[k])
    );
  end

  // Regular columns are written in SHF; the top column (always positive,
  // bits from the remaining scalars) is written in TOP.
  assign wr_en   = ph_shf | ph_top;
  assign wr_idx  = ph_top ? IDXW'(W) : iter;
  assign wr_data = ph_top ? pack_col(1'b1, {lane_acc[2][0], lane_acc[1][0], lane_acc[0][0]})
                          : pack_col(sgn_q, lane_bit);

  sar_colbuf #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ridx(rd_idx), .rdata(rd_col)
  );
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter  int W    = 64,
  localparam int IDXW = $clog2(W + 1),
  localparam int NAUX = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ph_load,
  input logic                   ph_sgn,
  input logic                   ph_top,
  input logic                   busy,
  input logic                   done,
  input logic [IDXW-1:0]        iter,
  input logic [W-1:0]           lead_q,
  input logic                   wr_en,
  input logic [IDXW-1:0]        wr_idx,
  input logic [3:0]             wr_data,
  input logic [NAUX-1:0][W-1:0] lane_acc
);
  localparam logic [31:0] LAT = 32'(6 * W + 1);

  logic [31:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_cnt <= '0;
    else if (ph_load) lat_cnt <= '0;
    else if (busy)    lat_cnt <= lat_cnt + 1'b1;
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LAT));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_top_positive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDXW'(W)) |-> wr_data[3]);

  p_iter_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (iter >= $past(iter)));

  p_lead_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_sgn && iter == '0) |-> lead_q[0]);

  for (genvar k = 0; k < NAUX; k++) begin : g_fin
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ph_top |-> (lane_acc[k] <= W'(1)));
  end
endmodule

bind sign_aligned_recoder sar_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph_load(ph_load), .ph_sgn(ph_sgn), .ph_top(ph_top),
  .busy(busy), .done(done), .iter(iter), .lead_q(lead_q), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .lane_acc(lane_acc)
);

// File: tb/sign_aligned_recoder_tb.sv
`timescale 1ns/1ps
module sign_aligned_recoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        sb = 0, ss = 0;
  logic [63:0] b0 = 0, b1 = 0, b2 = 0, b3 = 0;
  logic [2:0]  s0 = 0, s1 = 0, s2 = 0, s3 = 0;
  logic [6:0]  rib = 0;
  logic [1:0]  ris = 0;
  logic [3:0]  rcb, rcs;
  logic        db, ds;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [3:0] cols [0:64];

  sign_aligned_recoder #(.W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(sb), .lead_scalar(b0), .aux1_scalar(b1),
    .aux2_scalar(b2), .aux3_scalar(b3), .done(db), .rd_idx(rib), .rd_col(rcb));

  sign_aligned_recoder #(.W(3)) u_small (
    .clk(clk), .rst_n(rst_n), .start(ss), .lead_scalar(s0), .aux1_scalar(s1),
    .aux2_scalar(s2), .aux3_scalar(s3), .done(ds), .rd_idx(ris), .rd_col(rcs));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog R5: actual %0d cycles expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic read_cols(input bit sm);
    for (int j = 0; j < (sm ? 4 : 65); j++) begin
      if (sm) ris = 2'(j); else rib = 7'(j);
      #1;
      cols[j] = sm ? rcs : rcb;
    end
  endtask

  task automatic check_cols(input bit sm, input logic [63:0] l0, input logic [63:0] l1,
                            input logic [63:0] l2, input logic [63:0] l3);
    int w;
    logic [63:0] av [4];
    logic signed [71:0] acc;
    logic c, expbit;
    bit ok;
    w = sm ? 3 : 64;
    av[0] = l0; av[1] = l1; av[2] = l2; av[3] = l3;
    for (int k = 0; k < 4; k++) begin
      acc = '0;
      for (int j = 0; j <= w; j++) begin
        c = (k == 0) ? 1'b1 : cols[j][k-1];
        if (c) begin
          if (cols[j][3]) acc = acc + (72'sd1 <<< j);
          else            acc = acc - (72'sd1 <<< j);
        end
      end
      chk(acc == $signed({8'd0, av[k]}), "R1", $sformatf("rebuild scalar %0d", k),
          acc, {8'd0, av[k]});
    end
    ok = 1;
    for (int j = 0; j < w; j++) begin
      expbit = (j + 1 < w) ? av[0][j+1] : 1'b0;
      if (cols[j][3] != expbit) ok = 0;
    end
    chk(ok, "R2", "column signs from lead bits", 72'(ok), 72'(1));
    chk(cols[w][3] == 1'b1, "R4", "top column sign", 72'(cols[w][3]), 72'(1));
  endtask

  task automatic run(input bit sm, input logic [63:0] l0, input logic [63:0] l1,
                     input logic [63:0] l2, input logic [63:0] l3, input bit intrude);
    int lat;
    int exp_lat;
    exp_lat = sm ? 20 : 386;
    @(negedge clk);
    if (sm) begin
      s0 = l0[2:0]; s1 = l1[2:0]; s2 = l2[2:0]; s3 = l3[2:0]; ss = 1;
    end else begin
      b0 = l0; b1 = l1; b2 = l2; b3 = l3; sb = 1;
    end
    @(posedge clk); lat = 1; #1;
    ss = 0; sb = 0;
    while (((sm ? ds : db) == 1'b0) && lat < 1000) begin
      @(posedge clk); lat++; #1;
      if (intrude && lat == 50) begin
        b0 = ~l0 | 64'd1; b1 = ~l1; b2 = ~l2; b3 = ~l3; sb = 1;
      end else if (intrude && lat == 51) begin
        sb = 0;
      end
    end
    chk(lat == exp_lat, intrude ? "R7" : "R5", "latency to done", 72'(lat), 72'(exp_lat));
    @(posedge clk); #1;
    chk((sm ? ds : db) == 1'b0, "R6", "done falls after one cycle",
        72'(sm ? ds : db), 72'(0));
    read_cols(sm);
    check_cols(sm, l0, l1, l2, l3);
  endtask

  logic [63:0] x;
  logic [63:0] r0, r1, r2, r3;

  function automatic logic [63:0] nxt(input logic [63:0] v);
    logic [63:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  initial begin
    bit ok;
    repeat (3) @(posedge clk);
    #1;
    // R9: state under reset
    chk(db == 1'b0 && ds == 1'b0, "R9", "done low in reset", 72'({db, ds}), 72'(0));
    read_cols(0);
    ok = 1;
    for (int j = 0; j < 65; j++) if (cols[j] != 4'd0) ok = 0;
    chk(ok, "R9", "columns zero after reset", 72'(ok), 72'(1));
    @(negedge clk) rst_n = 1'b1;

    // Directed 64-bit vectors
    run(0, 64'd1, 64'd0, 64'd0, 64'd0, 0);
    run(0, '1, '1, '1, '1, 0);
    run(0, 64'd3, 64'd1, 64'd2, 64'd5, 0);
    run(0, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0);
    run(0, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5A5A_5A5A_5A5A_5A5A, '1, 0);

    // Pseudo-random 64-bit vectors
    x = 64'h0123_4567_89AB_CDEF;
    for (int n = 0; n < 30; n++) begin
      x = nxt(x); r0 = x | 64'd1;
      x = nxt(x); r1 = x;
      x = nxt(x); r2 = x;
      x = nxt(x); r3 = x;
      run(0, r0, r1, r2, r3, 0);
    end

    // R7: start in the middle of a run is ignored
    r0 = 64'hDEAD_BEEF_0BAD_F00D; r1 = 64'h1234_5678_9ABC_DEF0;
    r2 = 64'h0F0F_0F0F_F0F0_F0F0; r3 = 64'hFFFF_0000_FFFF_0000;
    run(0, r0, r1, r2, r3, 1);

    // R8: results held while inputs change and no start arrives
    @(negedge clk);
    b0 = 64'h7; b1 = '1; b2 = 64'd0; b3 = 64'h3;
    repeat (10) @(posedge clk);
    #1;
    read_cols(0);
    check_cols(0, r0, r1, r2, r3);
    chk(1, "R8", "columns held after done", 72'(1), 72'(1));

    // R3: indices above W read zero
    rib = 7'd65; #1;
    chk(rcb == 4'd0, "R3", "index 65 reads zero", 72'(rcb), 72'(0));
    rib = 7'd127; #1;
    chk(rcb == 4'd0, "R3", "index 127 reads zero", 72'(rcb), 72'(0));

    // Full sweep of the 3-bit configuration
    for (int a = 1; a < 8; a += 2)
      for (int p = 0; p < 8; p++)
        for (int q = 0; q < 8; q++)
          for (int r = 0; r < 8; r++)
            run(1, 64'(a), 64'(p), 64'(q), 64'(r), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule